// File: doc/BRIEF.md
# CPU Power-Zone Sequencer

This block controls the power zones of the cores in a multi-core cluster. Each core has five control outputs: an isolation clamp, a clock enable, a reset release, a memory-array power enable and a logic power-gate enable. Each core also returns two acknowledges from its analog power switches, one for memory power and one for logic power. A single command port takes a power-up or power-down request for one core. A shared sequencer then walks that core through a fixed order of control changes, one change per clock. At two points in each order it waits for an acknowledge to reach the needed level.

Each wait is bounded by a timeout. The timeout is set as a time in milliseconds together with the clock rate in kHz, and the block turns that into a cycle count. When the count runs out, the acknowledge is looked at once more before the sequence is abandoned. Every core exposes a 32-bit control/status word. A completed sequence gives a one-cycle done pulse. A timeout or a refused command sets a sticky error flag, which stays set until the next accepted command. Core 0 is the boot core and can never be powered down. A power-up request for a core whose reset is already released finishes at once and changes nothing.

Top module: `core_pwr_seq`

## Requirements
- R1: Word layout for each core. Bit 0 is the clock enable, bit 1 the reset release, bit 4 the memory power enable, bit 5 the logic power-gate enable, bit 6 isolation and bit 7 manual mode. Bit 29 is the sampled memory acknowledge and bit 28 the sampled logic acknowledge. Bit 26 is set when both acknowledges are set, and bit 25 is set when neither is. Bit 31 is set while the reset release (bit 1) is clear. All other bits read 0.
- R2: After reset, busy, done and err are low. Each core in BOOT_MASK has control byte 0x33 (clock, reset release, memory and logic power on). Every other core has control byte 0x00.
- R3: Each accepted sequence changes at most one control bit of one core per clock. The first change appears one clock after the accepting edge.
- R4: The first power-up step sets isolation and clears every other bit of the control byte, including manual mode.
- R5: Power-up order: isolation/clear, then manual mode on, then logic power gate on, then memory power on. It then waits for the memory acknowledge, turns the clock on, waits for the logic acknowledge, drops isolation and finally releases reset. From the off state the control byte therefore steps through 0x40, 0xC0, 0xE0, 0xF0, 0xF1, 0xB1 and 0xB3.
- R6: Power-down order: manual mode on, reset held, clock off, isolation on, memory power off. It then waits for the memory acknowledge to clear, turns the logic power gate off and waits for the logic acknowledge to clear. Steps that would not change a bit leave the byte as it is.
- R7: The logic power gate never turns off while the sampled memory acknowledge is set.
- R8: If a wait is still unmet after the timeout count, plus one final sample, err is set, busy drops, no done pulse follows and no further control change is made. err then stays high until the next accepted command.
- R9: A power-up command for a core whose bit 31 is clear gives a done pulse one clock after acceptance and changes no control bit.
- R10: A power-down command for core 0 is refused. err is set one clock later, busy stays low and no control bit changes.
- R11: While busy is high, cmd_valid is ignored.
- R12: done is a single-cycle pulse. It comes in the same cycle as the final control change (or in the cycle after the final wait is met), and only while busy is low. Accepting a command clears err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, accepted when busy is low |
| cmd_up | input | 1 | 1 requests power-up, 0 requests power-down |
| cmd_core | input | CW | Index of the target core |
| mem_ack | input | N_CORES | Memory power switch acknowledge, one bit per core |
| lgc_ack | input | N_CORES | Logic power switch acknowledge, one bit per core |
| pd_iso | output | N_CORES | Isolation clamp per core |
| pd_clk_en | output | N_CORES | Clock enable per core |
| pd_rst_rel | output | N_CORES | Reset release per core (1 runs the core) |
| pd_mem_en | output | N_CORES | Memory power enable per core |
| pd_lgc_en | output | N_CORES | Logic power-gate enable per core |
| zone_word | output | 32*N_CORES | Control/status word per core, core i at bits 32*i+31 to 32*i |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout or refusal flag |

## Verification
Refusals and power-up commands for a core that is already on are answered one clock after the accepting edge. The bench samples err or done at the falling edge right after that edge. A running sequence shows its first control change one clock after acceptance and then at most one change per clock, but the waits make the exact cycle depend on the acknowledge delay. The bench therefore queues the expected control bytes in order and compares each change of any core's control byte against the head of that queue at the falling edge where it appears. The done pulse must appear in the same falling-edge sample as the last expected change, and a timeout must show up as err with no done pulse.

// File: rtl/pzs_pkg.sv
package pzs_pkg;
  localparam int B_CLK   = 0;
  localparam int B_REL   = 1;
  localparam int B_MEM   = 4;
  localparam int B_LGC   = 5;
  localparam int B_ISO   = 6;
  localparam int B_MAN   = 7;
  localparam int B_OFF   = 25;
  localparam int B_ON    = 26;
  localparam int B_LST   = 28;
  localparam int B_MST   = 29;
  localparam int B_RSTST = 31;

  typedef enum logic [3:0] {
    OP_NONE, OP_ISO_INIT, OP_MAN_ON, OP_LGC_ON, OP_MEM_ON, OP_CLK_ON,
    OP_ISO_OFF, OP_RST_REL, OP_RST_HOLD, OP_CLK_OFF, OP_ISO_ON,
    OP_MEM_OFF, OP_LGC_OFF
  } op_e;

  typedef enum logic [4:0] {
    S_IDLE, S_U_ISO, S_U_MAN, S_U_LGC, S_U_MEM, S_U_WMEM, S_U_CLK,
    S_U_WLGC, S_U_NOISO, S_U_REL, S_D_MAN, S_D_RST, S_D_CLK, S_D_ISO,
    S_D_MEM, S_D_WMEM, S_D_LGC, S_D_WLGC
  } st_e;

  typedef struct packed {
    logic man;
    logic iso;
    logic lgc;
    logic mem;
    logic clk;
    logic rel;
  } ctl_t;
endpackage

// File: rtl/pzs_timer.sv
module pzs_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int TW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
  localparam logic [TW-1:0] LIM = TW'(LIMIT);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/pzs_bank.sv
module pzs_bank
  import pzs_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter logic [N_CORES-1:0] BOOT_MASK = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CORES-1:0] sel,
  input  op_e                op,
  input  logic [N_CORES-1:0] mem_ack,
  input  logic [N_CORES-1:0] lgc_ack,
  output ctl_t               ctl [N_CORES],
  output logic [N_CORES-1:0] mem_st,
  output logic [N_CORES-1:0] lgc_st
);
  localparam ctl_t CTL_ON  = '{man: 1'b0, iso: 1'b0, lgc: 1'b1, mem: 1'b1, clk: 1'b1, rel: 1'b1};
  localparam ctl_t CTL_OFF = '0;

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    ctl_t r;

    always_ff @(posedge clk) begin
      if (rst) begin
        r         <= BOOT_MASK[i] ? CTL_ON : CTL_OFF;
        mem_st[i] <= 1'b0;
        lgc_st[i] <= 1'b0;
      end else begin
        mem_st[i] <= mem_ack[i];
        lgc_st[i] <= lgc_ack[i];
        if (sel[i]) begin
          case (op)
            OP_ISO_INIT: r <= '{man: 1'b0, iso: 1'b1, lgc: 1'b0, mem: 1'b0, clk: 1'b0, rel: 1'b0};
            OP_MAN_ON:   r.man <= 1'b1;
            OP_LGC_ON:   r.lgc <= 1'b1;
            OP_MEM_ON:   r.mem <= 1'b1;
            OP_CLK_ON:   r.clk <= 1'b1;
            OP_ISO_OFF:  r.iso <= 1'b0;
            OP_RST_REL:  r.rel <= 1'b1;
            OP_RST_HOLD: r.rel <= 1'b0;
            OP_CLK_OFF:  r.clk <= 1'b0;
            OP_ISO_ON:   r.iso <= 1'b1;
            OP_MEM_OFF:  r.mem <= 1'b0;
            OP_LGC_OFF:  r.lgc <= 1'b0;
            default:     r <= r;
          endcase
        end
      end
    end

    assign ctl[i] = r;
  end
endmodule

// File: rtl/pzs_ctrl.sv
module pzs_ctrl
  import pzs_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_up,
  input  logic [CW-1:0] cmd_core,
  input  logic          req_rel,
  input  logic          cur_mst,
  input  logic          cur_lst,
  input  logic          tmo,
  output logic [CW-1:0] cur_core,
  output op_e           op,
  output logic          waiting,
  output logic          busy,
  output logic          done,
  output logic          err
);
  st_e  st;
  logic look;
  logic in_range;
  logic match;
  st_e  nxt_wait;

  assign in_range = (32'(cmd_core) < N_CORES);

  always_comb begin
    op = OP_NONE;
    case (st)
      S_U_ISO:   op = OP_ISO_INIT;
      S_U_MAN:   op = OP_MAN_ON;
      S_U_LGC:   op = OP_LGC_ON;
      S_U_MEM:   op = OP_MEM_ON;
      S_U_CLK:   op = OP_CLK_ON;
      S_U_NOISO: op = OP_ISO_OFF;
      S_U_REL:   op = OP_RST_REL;
      S_D_MAN:   op = OP_MAN_ON;
      S_D_RST:   op = OP_RST_HOLD;
      S_D_CLK:   op = OP_CLK_OFF;
      S_D_ISO:   op = OP_ISO_ON;
      S_D_MEM:   op = OP_MEM_OFF;
      S_D_LGC:   op = OP_LGC_OFF;
      default:   op = OP_NONE;
    endcase
  end

  always_comb begin
    waiting  = 1'b1;
    match    = 1'b0;
    nxt_wait = S_IDLE;
    case (st)
      S_U_WMEM: begin match = cur_mst;  nxt_wait = S_U_CLK;   end
      S_U_WLGC: begin match = cur_lst;  nxt_wait = S_U_NOISO; end
      S_D_WMEM: begin match = !cur_mst; nxt_wait = S_D_LGC;   end
      S_D_WLGC: begin match = !cur_lst; nxt_wait = S_IDLE;    end
      default:  waiting = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cur_core <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      look     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (waiting) begin
        if (match) begin
          look <= 1'b0;
          st   <= nxt_wait;
          if (st == S_D_WLGC) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else if (look) begin
          look <= 1'b0;
          err  <= 1'b1;
          busy <= 1'b0;
          st   <= S_IDLE;
        end else if (tmo) begin
          look <= 1'b1;
        end
      end else begin
        case (st)
          S_IDLE: begin
            if (cmd_valid) begin
              if (!in_range || (!cmd_up && cmd_core == '0)) begin
                err <= 1'b1;
              end else begin
                err      <= 1'b0;
                cur_core <= cmd_core;
                if (cmd_up && req_rel) begin
                  done <= 1'b1;
                end else begin
                  busy <= 1'b1;
                  st   <= cmd_up ? S_U_ISO : S_D_MAN;
                end
              end
            end
          end
          S_U_ISO:   st <= S_U_MAN;
          S_U_MAN:   st <= S_U_LGC;
          S_U_LGC:   st <= S_U_MEM;
          S_U_MEM:   st <= S_U_WMEM;
          S_U_CLK:   st <= S_U_WLGC;
          S_U_NOISO: st <= S_U_REL;
          S_U_REL: begin
            st   <= S_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end
          S_D_MAN:   st <= S_D_RST;
          S_D_RST:   st <= S_D_CLK;
          S_D_CLK:   st <= S_D_ISO;
          S_D_ISO:   st <= S_D_MEM;
          S_D_MEM:   st <= S_D_WMEM;
          S_D_LGC:   st <= S_D_WLGC;
          default:   st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import pzs_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int CLK_KHZ = 100000,
  parameter int TMO_MS = 500,
  parameter logic [N_CORES-1:0] BOOT_MASK = 1,
  localparam int CW = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic                 cmd_up,
  input  logic [CW-1:0]        cmd_core,
  input  logic [N_CORES-1:0]   mem_ack,
  input  logic [N_CORES-1:0]   lgc_ack,
  output logic [N_CORES-1:0]   pd_iso,
  output logic [N_CORES-1:0]   pd_clk_en,
  output logic [N_CORES-1:0]   pd_rst_rel,
  output logic [N_CORES-1:0]   pd_mem_en,
  output logic [N_CORES-1:0]   pd_lgc_en,
  output logic [32*N_CORES-1:0] zone_word,
  output logic                 busy,
  output logic                 done,
  output logic                 err
);
  localparam int TMO_CYCLES = CLK_KHZ * TMO_MS;

  ctl_t               ctl [N_CORES];
  logic [N_CORES-1:0] mem_st;
  logic [N_CORES-1:0] lgc_st;
  logic [N_CORES-1:0] sel;
  logic [CW-1:0]      cur_core;
  op_e                op;
  logic               waiting;
  logic               tmo;
  logic               req_rel;

  assign sel     = (op == OP_NONE) ? '0 : (N_CORES'(1) << cur_core);
  assign req_rel = pd_rst_rel[cmd_core];

  pzs_bank #(.N_CORES(N_CORES), .BOOT_MASK(BOOT_MASK)) u_bank (
    .clk(clk), .rst(rst), .sel(sel), .op(op),
    .mem_ack(mem_ack), .lgc_ack(lgc_ack),
    .ctl(ctl), .mem_st(mem_st), .lgc_st(lgc_st)
  );

  pzs_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .run(waiting), .expired(tmo)
  );

  pzs_ctrl #(.N_CORES(N_CORES), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_up(cmd_up),
    .cmd_core(cmd_core), .req_rel(req_rel),
    .cur_mst(mem_st[cur_core]), .cur_lst(lgc_st[cur_core]), .tmo(tmo),
    .cur_core(cur_core), .op(op), .waiting(waiting),
    .busy(busy), .done(done), .err(err)
  );

  for (genvar i = 0; i < N_CORES; i++) begin : g_out
    logic [31:0] w;
    always_comb begin
      w          = '0;
      w[B_CLK]   = ctl[i].clk;
      w[B_REL]   = ctl[i].rel;
      w[B_MEM]   = ctl[i].mem;
      w[B_LGC]   = ctl[i].lgc;
      w[B_ISO]   = ctl[i].iso;
      w[B_MAN]   = ctl[i].man;
      w[B_MST]   = mem_st[i];
      w[B_LST]   = lgc_st[i];
      w[B_ON]    = mem_st[i] & lgc_st[i];
      w[B_OFF]   = ~mem_st[i] & ~lgc_st[i];
      w[B_RSTST] = ~ctl[i].rel;
    end
    assign zone_word[32*i +: 32] = w;
    assign pd_iso[i]     = ctl[i].iso;
    assign pd_clk_en[i]  = ctl[i].clk;
    assign pd_rst_rel[i] = ctl[i].rel;
    assign pd_mem_en[i]  = ctl[i].mem;
    assign pd_lgc_en[i]  = ctl[i].lgc;
  end
endmodule

// File: rtl/core_pwr_seq_chk.sv
module core_pwr_seq_chk #(
  parameter int N_CORES = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cmd_valid,
  input logic                  busy,
  input logic                  done,
  input logic                  err,
  input logic [N_CORES-1:0]    pd_iso,
  input logic [N_CORES-1:0]    pd_clk_en,
  input logic [N_CORES-1:0]    pd_rst_rel,
  input logic [N_CORES-1:0]    pd_lgc_en,
  input logic [32*N_CORES-1:0] zone_word
);
  logic [7:0]         prev_b [N_CORES];
  logic [N_CORES-1:0] chg;

  for (genvar i = 0; i < N_CORES; i++) begin : g_chk
    always_ff @(posedge clk) prev_b[i] <= zone_word[32*i +: 8];
    assign chg[i] = (prev_b[i] != zone_word[32*i +: 8]);

    p_clk_needs_mem_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(pd_clk_en[i]) |-> zone_word[32*i+29]);
    p_iso_drop_needs_lgc_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(pd_iso[i]) |-> zone_word[32*i+28]);
    p_lgc_off_after_mem_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(pd_lgc_en[i]) |-> !zone_word[32*i+29]);
  end

  p_one_core_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(chg) <= 1);
  p_core0_kept_r10: assert property (@(posedge clk) disable iff (rst)
    !$fell(pd_rst_rel[0]));
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err && !cmd_valid |=> err);
endmodule

bind core_pwr_seq core_pwr_seq_chk #(.N_CORES(N_CORES)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .err(err), .pd_iso(pd_iso), .pd_clk_en(pd_clk_en), .pd_rst_rel(pd_rst_rel),
  .pd_lgc_en(pd_lgc_en), .zone_word(zone_word)
);

// File: tb/sim_core_pwr_seq.sv
`timescale 1ns/1ps
module sim_core_pwr_seq;
  localparam int N = 4;
  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_up = 1'b0;
  logic [1:0] cmd_core = '0;
  logic [N-1:0] mem_ack, lgc_ack;
  logic [N-1:0] pd_iso, pd_clk_en, pd_rst_rel, pd_mem_en, pd_lgc_en;
  logic [32*N-1:0] zone_word;
  logic busy, done, err;
  logic [N-1:0] stuck_mem = '0;

  always #5 clk = ~clk;

  core_pwr_seq #(.N_CORES(N), .CLK_KHZ(1), .TMO_MS(20), .BOOT_MASK(4'b0001)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_up(cmd_up),
    .cmd_core(cmd_core), .mem_ack(mem_ack), .lgc_ack(lgc_ack),
    .pd_iso(pd_iso), .pd_clk_en(pd_clk_en), .pd_rst_rel(pd_rst_rel),
    .pd_mem_en(pd_mem_en), .pd_lgc_en(pd_lgc_en), .zone_word(zone_word),
    .busy(busy), .done(done), .err(err)
  );

  // switch model: acknowledges follow the enables after DLY cycles
  logic [DLY-1:0] msh [N];
  logic [DLY-1:0] lsh [N];
  initial for (int i = 0; i < N; i++) begin msh[i] = '0; lsh[i] = '0; end
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      msh[i] <= {msh[i][DLY-2:0], pd_mem_en[i] & ~stuck_mem[i]};
      lsh[i] <= {lsh[i][DLY-2:0], pd_lgc_en[i]};
    end
  end
  always_comb for (int i = 0; i < N; i++) begin
    mem_ack[i] = msh[i][DLY-1];
    lgc_ack[i] = lsh[i][DLY-1];
  end

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;
  bit mon_on = 0;

  // scoreboard queues
  int         q_core[$];
  logic [7:0] q_val[$];
  string      q_tag[$];
  int         ev_kind[$];
  string      ev_tag[$];
  logic [7:0] mdl [N];
  logic [7:0] prev_b [N];
  logic       err_d = 1'b0;

  function automatic logic [31:0] wd(int c);
    return zone_word[32*c +: 32];
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // op codes of the bench model: 1 iso-init 2 man 3 lgc 4 mem 5 clk 6 iso-off
  // 7 release 8 hold 9 clk-off 10 iso-on 11 mem-off 12 lgc-off
  function automatic logic [7:0] apply(logic [7:0] b, int o);
    case (o)
      1:  return 8'h40;
      2:  return b | 8'h80;
      3:  return b | 8'h20;
      4:  return b | 8'h10;
      5:  return b | 8'h01;
      6:  return b & ~8'h40;
      7:  return b | 8'h02;
      8:  return b & ~8'h02;
      9:  return b & ~8'h01;
      10: return b | 8'h40;
      11: return b & ~8'h10;
      default: return b & ~8'h20;
    endcase
  endfunction

  task automatic push_ops(int c, int ops[$], string tag);
    foreach (ops[k]) begin
      logic [7:0] nb;
      nb = apply(mdl[c], ops[k]);
      if (nb != mdl[c]) begin
        q_core.push_back(c); q_val.push_back(nb); q_tag.push_back(tag);
        mdl[c] = nb;
      end
    end
  endtask

  task automatic send(bit up, int c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_up = up; cmd_core = 2'(c);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic wait_drain(string tag);
    int n;
    n = 0;
    while ((q_val.size() != 0 || ev_kind.size() != 0) && n < 400) begin
      @(negedge clk); n++;
    end
    chk(n < 400, {tag, " sequence completes"}, 32'(q_val.size()), 0);
    repeat (DLY + 3) @(negedge clk);
  endtask

  // monitor: compares each control change and each done/err event
  always @(negedge clk) begin
    if (mon_on) begin
      for (int i = 0; i < N; i++) begin
        if (wd(i)[7:0] != prev_b[i]) begin
          if (q_val.size() == 0) begin
            chk(0, "R11 unexpected control change", {24'(i), wd(i)[7:0]}, {24'(i), prev_b[i]});
          end else begin
            int c; logic [7:0] v; string t;
            c = q_core.pop_front(); v = q_val.pop_front(); t = q_tag.pop_front();
            chk(c == i && v == wd(i)[7:0], t, {24'(i), wd(i)[7:0]}, {24'(c), v});
          end
          prev_b[i] = wd(i)[7:0];
        end
      end
      if (done) begin
        if (ev_kind.size() == 0 || ev_kind[0] != 0)
          chk(0, "R12 unexpected done", 1, 0);
        else begin
          string t;
          void'(ev_kind.pop_front()); t = ev_tag.pop_front();
          chk(q_val.size() == 0, t, 32'(q_val.size()), 0);
        end
      end
      if (err && !err_d) begin
        if (ev_kind.size() == 0 || ev_kind[0] != 1)
          chk(0, "R8 unexpected err", 1, 0);
        else begin
          string t;
          void'(ev_kind.pop_front()); t = ev_tag.pop_front();
          chk(q_val.size() == 0, t, 32'(q_val.size()), 0);
        end
      end
      err_d = err;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (6) @(posedge clk);
    rst = 1'b0;
    repeat (DLY + 3) @(negedge clk);
    // R2 / R1: reset state
    chk(!busy && !done && !err, "R2 flags after reset", {busy, done, err}, 0);
    chk(wd(0)[7:0] == 8'h33, "R2 boot core byte", wd(0)[7:0], 8'h33);
    chk(wd(1)[7:0] == 8'h00, "R2 off core byte", wd(1)[7:0], 8'h00);
    chk(wd(0) == 32'h3400_0033, "R1 boot core word", wd(0), 32'h3400_0033);
    chk(wd(1) == 32'h8200_0000, "R1 off core word", wd(1), 32'h8200_0000);
    for (int i = 0; i < N; i++) begin mdl[i] = wd(i)[7:0]; prev_b[i] = wd(i)[7:0]; end
    mon_on = 1;

    // R5 / R4 / R3: power-up of core 1
    push_ops(1, '{1, 2, 3, 4, 5, 6, 7}, "R5 up order core1");
    ev_kind.push_back(0); ev_tag.push_back("R12 done with last change core1");
    send(1, 1);
    @(negedge clk);
    chk(busy && wd(1)[7:0] == 8'h00, "R3 no change on accept edge", {busy, wd(1)[7:0]}, {1'b1, 8'h00});
    wait_drain("R5");
    chk(wd(1) == 32'h3400_00B3, "R1 powered core word", wd(1), 32'h3400_00B3);

    // R11: command during busy is ignored
    push_ops(2, '{1, 2, 3, 4, 5, 6, 7}, "R5 up order core2");
    ev_kind.push_back(0); ev_tag.push_back("R12 done core2");
    send(1, 2);
    send(0, 3);
    wait_drain("R11");
    chk(wd(3)[7:0] == 8'h00, "R11 core3 untouched", wd(3)[7:0], 8'h00);

    // R9: power-up of an already running core
    ev_kind.push_back(0); ev_tag.push_back("R9 already on done");
    send(1, 1);
    @(negedge clk);
    chk(done && !busy, "R9 done one clock after accept", {done, busy}, 2'b10);
    wait_drain("R9");

    // R10: power-down of core 0 refused
    ev_kind.push_back(1); ev_tag.push_back("R10 refusal err");
    send(0, 0);
    @(negedge clk);
    chk(err && !busy, "R10 err set busy low", {err, busy}, 2'b10);
    wait_drain("R10");
    chk(wd(0)[7:0] == 8'h33, "R10 core0 unchanged", wd(0)[7:0], 8'h33);

    // R6 / R7: power-down of core 1, also clears err (R12)
    push_ops(1, '{2, 8, 9, 10, 11, 12}, "R6 down order core1");
    ev_kind.push_back(0); ev_tag.push_back("R7 done after logic ack clear");
    send(0, 1);
    @(negedge clk);
    chk(!err, "R12 err cleared by accepted command", err, 0);
    wait_drain("R6");
    chk(wd(1) == 32'h8200_00C0, "R6 core1 off word", wd(1), 32'h8200_00C0);

    // R4: power-up from manual-mode off state clears manual first
    push_ops(1, '{1, 2, 3, 4, 5, 6, 7}, "R4 up from off manual");
    ev_kind.push_back(0); ev_tag.push_back("R12 done core1 again");
    send(1, 1);
    wait_drain("R4");

    // R8: memory acknowledge stuck low
    stuck_mem[3] = 1'b1;
    push_ops(3, '{1, 2, 3, 4}, "R8 steps before timeout");
    ev_kind.push_back(1); ev_tag.push_back("R8 timeout err");
    send(1, 3);
    wait_drain("R8");
    repeat (10) @(negedge clk);
    chk(err && !busy && wd(3)[7:0] == 8'hF0, "R8 err sticky no change",
        {err, busy, wd(3)[7:0]}, {1'b1, 1'b0, 8'hF0});

    // power-down of the stuck core completes (memory ack already low)
    push_ops(3, '{2, 8, 9, 10, 11, 12}, "R6 down after timeout");
    ev_kind.push_back(0); ev_tag.push_back("R12 done core3");
    send(0, 3);
    wait_drain("R6b");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule